// File: doc/BRIEF.md
# Not-Recently-Used Victim Selector

This block keeps two status bits for every resident page frame: a referenced bit and a modified bit. Access strobes carry a frame index and set the bits. A read sets only the referenced bit, and a write sets both. A periodic tick input clears every referenced bit and leaves the modified bits alone. When a page fault needs a frame, the block puts each frame that is not marked busy into a class, numbered twice the referenced bit plus the modified bit. It then offers one frame from the lowest-numbered class that has any members, together with a flag that says whether the frame must be written back before it is reused.

The choice within a class is pseudo-random. A free-running 16-bit LFSR gives the start index of a rotating priority scan over the members of the selected class. The loader raises `fault_req` for one cycle. On the next cycle the block presents `victim_valid` with the index, the dirty flag and a none flag, and it holds them steady until the loader answers with `victim_ack`. The acknowledge commits the replacement and clears both status bits of the offered frame.

The control is a two-state machine. In `ST_IDLE`, a `fault_req` takes the transition `IDLE_TO_OFFER`: the block captures the pick and enters `ST_OFFER`. In `ST_OFFER`, a `victim_ack` takes the transition `OFFER_TO_IDLE`. Without that strobe, the machine stays in its state (`IDLE_HOLD`, `OFFER_HOLD`).

Top module: `nru_victim_sel`

## Requirements
- R1: After reset, `victim_valid` is 0 and every referenced and modified bit is 0, so the first victim offered has `victim_dirty` = 0.
- R2: An access with `ref_valid`=1 and `ref_write`=0 sets only the referenced bit of frame `ref_idx`. An access with `ref_write`=1 sets both the referenced and the modified bit of that frame.
- R3: A cycle with `tick`=1 clears the referenced bit of every frame and leaves every modified bit unchanged.
- R4: If `tick` and an access to a frame arrive in the same cycle, that frame's referenced bit ends up set.
- R5: The class of a frame is 2*R+M (0: clean and unreferenced, 1: modified only, 2: referenced only, 3: both). The offered frame belongs to the lowest class that has at least one frame not masked in `busy_mask`.
- R6: A `fault_req` sampled in `ST_IDLE` makes `victim_valid` 1 from the next cycle on. `victim_idx`, `victim_dirty` and `victim_none` stay stable until the cycle after `victim_ack`.
- R7: `victim_dirty` equals the modified bit of the offered frame as it stood in the cycle the request was sampled.
- R8: A frame whose `busy_mask` bit is 1 in the request cycle is never offered. If every frame is masked, the block answers with `victim_none`=1.
- R9: A `victim_ack` while `victim_valid` is 1 drops `victim_valid` in the next cycle and clears both bits of the offered frame, unless an access to that frame in the same cycle sets them again.
- R10: `fault_req` while an offer is pending, and `victim_ack` while idle, have no effect.
- R11: When several frames share the selected class, repeated faults do not always return the same frame: the LFSR value moves the start of the scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | 1 | Access strobe |
| ref_idx | input | IDXW | Frame index of the access |
| ref_write | input | 1 | Access is a write (also sets the modified bit) |
| tick | input | 1 | Periodic clear of all referenced bits |
| fault_req | input | 1 | Request for a victim frame |
| busy_mask | input | NFRAMES | Frames that must not be chosen, sampled with the request |
| victim_ack | input | 1 | Loader commits the offered replacement |
| victim_valid | output | 1 | An offer is pending |
| victim_idx | output | IDXW | Offered frame |
| victim_dirty | output | 1 | Offered frame must be written back |
| victim_none | output | 1 | No frame was eligible |

## Verification
Status-bit updates take effect at the clock edge that samples the access or tick. A request issued in the same cycle therefore still sees the old bits, and a request in any later cycle sees the new ones. The offer appears one edge after `fault_req`, and it disappears one edge after `victim_ack`. The bench drives inputs on the falling edge and samples outputs 1 ns after the next rising edge. It judges each offer against a snapshot of its own bit model taken before that edge, so each check lands in the cycle where its result is due.

// File: rtl/nru_pkg.sv
package nru_pkg;

    localparam int NUM_CLASSES = 4;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } nru_state_e;

    // class number: referenced bit is the high bit, modified bit the low bit
    function automatic logic [1:0] frame_class(input logic r, input logic m);
        return {r, m};
    endfunction

endpackage

// File: rtl/nru_lfsr.sv
module nru_lfsr #(
    parameter int          WIDTH = 16,
    parameter logic [15:0] TAPS  = 16'hB400,
    parameter logic [15:0] SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [WIDTH-1:0] state_o
);

    localparam logic [WIDTH-1:0] TAP_MASK  = WIDTH'(TAPS);
    localparam logic [WIDTH-1:0] SEED_VAL  = WIDTH'(SEED);

    logic [WIDTH-1:0] lfsr_q;

    // Galois form; free-running, never reaches the all-zero state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q <= SEED_VAL;
        end else if (lfsr_q[0]) begin
            lfsr_q <= (lfsr_q >> 1) ^ TAP_MASK;
        end else begin
            lfsr_q <= lfsr_q >> 1;
        end
    end

    assign state_o = lfsr_q;

endmodule

// File: rtl/nru_status_bits.sv
module nru_status_bits #(
    parameter int NFRAMES = 8,
    parameter int IDXW    = $clog2(NFRAMES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_valid_i,
    input  logic [IDXW-1:0]    ref_idx_i,
    input  logic               ref_write_i,
    input  logic               tick_i,
    input  logic               clr_valid_i,
    input  logic [IDXW-1:0]    clr_idx_i,
    output logic [NFRAMES-1:0] ref_bits_o,
    output logic [NFRAMES-1:0] mod_bits_o
);

    for (genvar f = 0; f < NFRAMES; f++) begin : g_frame
        logic hit;
        logic clr;
        logic r_q;
        logic m_q;

        assign hit = ref_valid_i && (ref_idx_i == IDXW'(f));
        assign clr = clr_valid_i && (clr_idx_i == IDXW'(f));

        // an access outranks both the tick and the commit clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                r_q <= 1'b0;
                m_q <= 1'b0;
            end else begin
                r_q <= hit || (r_q && !tick_i && !clr);
                m_q <= (hit && ref_write_i) || (m_q && !clr);
            end
        end

        assign ref_bits_o[f] = r_q;
        assign mod_bits_o[f] = m_q;
    end

endmodule

// File: rtl/nru_class_pick.sv
module nru_class_pick
    import nru_pkg::*;
#(
    parameter int NFRAMES = 8,
    parameter int IDXW    = $clog2(NFRAMES),
    parameter int RANDW   = 16
) (
    input  logic [NFRAMES-1:0] ref_bits_i,
    input  logic [NFRAMES-1:0] mod_bits_i,
    input  logic [NFRAMES-1:0] avail_i,
    input  logic [RANDW-1:0]   rand_i,
    output logic               found_o,
    output logic [IDXW-1:0]    idx_o,
    output logic               dirty_o
);

    localparam logic [RANDW-1:0] NF_R = RANDW'(NFRAMES);

    logic [NFRAMES-1:0] cls_mask [NUM_CLASSES];
    logic [NFRAMES-1:0] sel_mask;
    logic [RANDW-1:0]   start_full;
    logic [IDXW-1:0]    start;

    // group eligible frames by class
    always_comb begin
        for (int c = 0; c < NUM_CLASSES; c++) begin
            for (int f = 0; f < NFRAMES; f++) begin
                cls_mask[c][f] = avail_i[f] &&
                    (frame_class(ref_bits_i[f], mod_bits_i[f]) == 2'(c));
            end
        end
    end

    // lowest non-empty class wins (scan from the top so the lowest is last)
    always_comb begin
        sel_mask = '0;
        for (int c = NUM_CLASSES - 1; c >= 0; c--) begin
            if (|cls_mask[c]) begin
                sel_mask = cls_mask[c];
            end
        end
    end

    assign start_full = rand_i % NF_R;
    assign start      = start_full[IDXW-1:0];

    // rotating priority scan starting at the random index
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int k = 0; k < NFRAMES; k++) begin
            int p;
            p = (int'(start) + k) % NFRAMES;
            if (!found_o && sel_mask[p]) begin
                found_o = 1'b1;
                idx_o   = IDXW'(p);
            end
        end
    end

    assign dirty_o = found_o && mod_bits_i[idx_o];

endmodule

// File: rtl/nru_victim_sel.sv
module nru_victim_sel
    import nru_pkg::*;
#(
    parameter int NFRAMES = 8,
    parameter int LFSR_W  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ref_valid,
    input  logic [$clog2(NFRAMES)-1:0] ref_idx,
    input  logic                       ref_write,
    input  logic                       tick,
    input  logic                       fault_req,
    input  logic [NFRAMES-1:0]         busy_mask,
    input  logic                       victim_ack,
    output logic                       victim_valid,
    output logic [$clog2(NFRAMES)-1:0] victim_idx,
    output logic                       victim_dirty,
    output logic                       victim_none
);

    localparam int IDXW = $clog2(NFRAMES);

    nru_state_e        state_q;
    nru_state_e        state_d;
    logic [NFRAMES-1:0] ref_bits;
    logic [NFRAMES-1:0] mod_bits;
    logic [LFSR_W-1:0]  rnd;
    logic               pick_found;
    logic [IDXW-1:0]    pick_idx;
    logic               pick_dirty;
    logic               accept;
    logic               commit;
    logic [IDXW-1:0]    idx_q;
    logic               dirty_q;
    logic               none_q;

    nru_lfsr #(
        .WIDTH (LFSR_W)
    ) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_o (rnd)
    );

    nru_status_bits #(
        .NFRAMES (NFRAMES),
        .IDXW    (IDXW)
    ) u_bits (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_valid_i (ref_valid),
        .ref_idx_i   (ref_idx),
        .ref_write_i (ref_write),
        .tick_i      (tick),
        .clr_valid_i (commit),
        .clr_idx_i   (idx_q),
        .ref_bits_o  (ref_bits),
        .mod_bits_o  (mod_bits)
    );

    nru_class_pick #(
        .NFRAMES (NFRAMES),
        .IDXW    (IDXW),
        .RANDW   (LFSR_W)
    ) u_pick (
        .ref_bits_i (ref_bits),
        .mod_bits_i (mod_bits),
        .avail_i    (~busy_mask),
        .rand_i     (rnd),
        .found_o    (pick_found),
        .idx_o      (pick_idx),
        .dirty_o    (pick_dirty)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (fault_req)  state_d = ST_OFFER;  // IDLE_TO_OFFER
            ST_OFFER: if (victim_ack) state_d = ST_IDLE;   // OFFER_TO_IDLE
            default:  state_d = ST_IDLE;
        endcase
    end

    assign accept = (state_q == ST_IDLE) && fault_req;
    assign commit = (state_q == ST_OFFER) && victim_ack && !none_q;

    // offer registers, captured only on an accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            dirty_q <= 1'b0;
            none_q  <= 1'b0;
        end else if (accept) begin
            idx_q   <= pick_idx;
            dirty_q <= pick_dirty;
            none_q  <= !pick_found;
        end
    end

    assign victim_valid = (state_q == ST_OFFER);
    assign victim_idx   = idx_q;
    assign victim_dirty = dirty_q;
    assign victim_none  = none_q;

endmodule

// File: rtl/nru_victim_sel_chk.sv
module nru_victim_sel_chk #(
    parameter int NFRAMES = 8,
    parameter int IDXW    = $clog2(NFRAMES)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ref_valid,
    input logic [IDXW-1:0]    ref_idx,
    input logic               ref_write,
    input logic               tick,
    input logic               fault_req,
    input logic [NFRAMES-1:0] busy_mask,
    input logic               victim_ack,
    input logic               victim_valid,
    input logic [IDXW-1:0]    victim_idx,
    input logic               victim_dirty,
    input logic               victim_none,
    input logic [NFRAMES-1:0] ref_bits,
    input logic [NFRAMES-1:0] mod_bits
);

    logic [NFRAMES-1:0] busy_snap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_snap <= '0;
        end else if (!victim_valid && fault_req) begin
            busy_snap <= busy_mask;
        end
    end

    AST_READ_SETS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |=> ref_bits[$past(ref_idx)]); // R2

    AST_WRITE_SETS_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid && ref_write) |=> mod_bits[$past(ref_idx)]); // R2

    AST_TICK_CLEARS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ref_valid) |=> (ref_bits == '0)); // R3

    AST_TICK_KEEPS_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ref_valid && !(victim_valid && victim_ack)) |=> $stable(mod_bits)); // R3

    AST_TICK_REF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && ref_valid) |=> ref_bits[$past(ref_idx)]); // R4

    AST_OFFER_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!victim_valid && fault_req) |=> victim_valid); // R6

    AST_OFFER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_valid && !victim_ack) |=>
            (victim_valid && $stable(victim_idx) && $stable(victim_dirty) && $stable(victim_none))); // R6

    AST_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_valid && !victim_none) |-> !busy_snap[victim_idx]); // R8

    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_valid && victim_ack) |=> !victim_valid); // R9

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (victim_valid && victim_ack && !victim_none && !ref_valid) |=>
            (!ref_bits[$past(victim_idx)] && !mod_bits[$past(victim_idx)])); // R9

    AST_IDLE_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!victim_valid && !fault_req) |=> !victim_valid); // R10

endmodule

bind nru_victim_sel nru_victim_sel_chk #(
    .NFRAMES (NFRAMES),
    .IDXW    (IDXW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_valid    (ref_valid),
    .ref_idx      (ref_idx),
    .ref_write    (ref_write),
    .tick         (tick),
    .fault_req    (fault_req),
    .busy_mask    (busy_mask),
    .victim_ack   (victim_ack),
    .victim_valid (victim_valid),
    .victim_idx   (victim_idx),
    .victim_dirty (victim_dirty),
    .victim_none  (victim_none),
    .ref_bits     (ref_bits),
    .mod_bits     (mod_bits)
);

// File: tb/sim_nru_victim_sel.sv
`timescale 1ns/100ps
module sim_nru_victim_sel;

    localparam int N  = 8;
    localparam int IW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_valid = 1'b0;
    logic [IW-1:0] ref_idx = '0;
    logic          ref_write = 1'b0;
    logic          tick = 1'b0;
    logic          fault_req = 1'b0;
    logic [N-1:0]  busy_mask = '0;
    logic          victim_ack = 1'b0;
    logic          victim_valid;
    logic [IW-1:0] victim_idx;
    logic          victim_dirty;
    logic          victim_none;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // bench model of the status bits and the offer
    logic [N-1:0]  mr = '0;
    logic [N-1:0]  mm = '0;
    bit            hold = 1'b0;
    logic [IW-1:0] exp_idx = '0;
    logic          exp_dirty = 1'b0;
    logic          exp_none = 1'b0;
    logic [IW-1:0] last_idx = '0;

    always #2.5 clk = ~clk;

    nru_victim_sel #(.NFRAMES(N)) u0 (
        .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_idx(ref_idx),
        .ref_write(ref_write), .tick(tick), .fault_req(fault_req),
        .busy_mask(busy_mask), .victim_ack(victim_ack),
        .victim_valid(victim_valid), .victim_idx(victim_idx),
        .victim_dirty(victim_dirty), .victim_none(victim_none)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic int cls(input logic r, input logic m);
        return (r ? 2 : 0) + (m ? 1 : 0);
    endfunction

    function automatic int lowest(input logic [N-1:0] r, input logic [N-1:0] m,
                                  input logic [N-1:0] bm);
        int lo = 4;
        for (int f = 0; f < N; f++) begin
            if (!bm[f] && cls(r[f], m[f]) < lo) lo = cls(r[f], m[f]);
        end
        return lo;
    endfunction

    task automatic judge_offer(input logic [N-1:0] pr, input logic [N-1:0] pm,
                               input logic [N-1:0] bm);
        int lc = lowest(pr, pm, bm);
        check(victim_valid == 1'b1, "R6 valid after request", victim_valid, 1);
        if (lc == 4) begin
            check(victim_none == 1'b1, "R8 none when all busy", victim_none, 1);
        end else begin
            check(victim_none == 1'b0, "R8 none flag", victim_none, 0);
            check(bm[victim_idx] == 1'b0, "R8 busy frame offered", victim_idx, -1);
            check(cls(pr[victim_idx], pm[victim_idx]) == lc, "R5 lowest class",
                  cls(pr[victim_idx], pm[victim_idx]), lc);
            check(victim_dirty == pm[victim_idx], "R7 dirty flag", victim_dirty, pm[victim_idx]);
        end
        exp_idx   = victim_idx;
        exp_dirty = victim_dirty;
        exp_none  = victim_none;
        last_idx  = victim_idx;
    endtask

    task automatic cyc(input logic rv, input logic [IW-1:0] ri, input logic rw,
                       input logic tk, input logic fr, input logic [N-1:0] bm,
                       input logic ak);
        logic [N-1:0] pr;
        logic [N-1:0] pm;
        bit           was_hold;
        @(negedge clk);
        ref_valid = rv; ref_idx = ri; ref_write = rw; tick = tk;
        fault_req = fr; busy_mask = bm; victim_ack = ak;
        pr = mr; pm = mm; was_hold = hold;
        @(posedge clk);
        #1;
        for (int f = 0; f < N; f++) begin
            bit hit = rv && (ri == IW'(f));
            bit clr = was_hold && ak && !exp_none && (exp_idx == IW'(f));
            mr[f] = hit || (pr[f] && !tk && !clr);
            mm[f] = (hit && rw) || (pm[f] && !clr);
        end
        if (!was_hold && fr) begin
            judge_offer(pr, pm, bm);
            hold = 1'b1;
        end else if (was_hold && ak) begin
            hold = 1'b0;
            check(victim_valid == 1'b0, "R9 valid drops after ack", victim_valid, 0);
        end else if (was_hold) begin
            check(victim_valid && victim_idx == exp_idx && victim_dirty == exp_dirty
                  && victim_none == exp_none, "R6 R10 offer stable", victim_idx, exp_idx);
        end else begin
            check(victim_valid == 1'b0, "R10 idle stays idle", victim_valid, 0);
        end
    endtask

    task automatic idle(); cyc(0, '0, 0, 0, 0, '0, 0); endtask
    task automatic rd(input int f); cyc(1, IW'(f), 0, 0, 0, '0, 0); endtask
    task automatic wr(input int f); cyc(1, IW'(f), 1, 0, 0, '0, 0); endtask
    task automatic fault(input logic [N-1:0] bm); cyc(0, '0, 0, 0, 1, bm, 0); endtask
    task automatic ack(); cyc(0, '0, 0, 0, 0, '0, 1); endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin
        void'($urandom(32'd31337));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(victim_valid == 1'b0, "R1 reset valid", victim_valid, 0);

        // R1: first offer after reset is clean
        fault('0);
        check(victim_dirty == 1'b0, "R1 clean after reset", victim_dirty, 0);
        ack();

        // R2 / R9: all written, offer is dirty; after commit that frame alone is class 0
        for (int f = 0; f < N; f++) wr(f);
        fault('0);
        check(victim_dirty == 1'b1, "R2 write sets modified", victim_dirty, 1);
        begin
            logic [IW-1:0] first = last_idx;
            ack();
            fault('0);
            check(last_idx == first, "R9 cleared frame reoffered", last_idx, first);
            check(victim_dirty == 1'b0, "R9 cleared frame clean", victim_dirty, 0);
            ack();
        end

        // R3: tick clears referenced, keeps modified
        rst_n = 1'b0; idle(); mr = '0; mm = '0; hold = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        wr(2); rd(4);
        cyc(0, '0, 0, 1, 0, '0, 0);
        fault(~(N'(1) << 2 | N'(1) << 4));
        check(last_idx == IW'(4), "R3 unreferenced clean frame first", last_idx, 4);
        check(victim_dirty == 1'b0, "R3 frame 4 clean", victim_dirty, 0);
        ack();
        fault(~(N'(1) << 2));
        check(last_idx == IW'(2) && victim_dirty == 1'b1, "R3 modified kept over tick",
              victim_dirty, 1);
        ack();

        // R4: tick and read of frame 6 together; frame 7 stays lower class
        cyc(1, IW'(6), 0, 1, 0, '0, 0);
        for (int i = 0; i < 4; i++) begin
            fault(~(N'(1) << 6 | N'(1) << 7));
            check(last_idx == IW'(7), "R4 reference wins over tick", last_idx, 7);
            ack();
            idle();
        end

        // R8: everything busy
        fault('1);
        check(victim_none == 1'b1, "R8 all busy gives none", victim_none, 1);
        ack();

        // R10: request while pending and ack while idle are ignored
        ack();
        fault('0);
        fault(N'(1) << last_idx);
        idle();
        ack();

        // R11: the scan start moves
        cyc(0, '0, 0, 1, 0, '0, 0);
        begin
            logic [N-1:0] seen = '0;
            for (int i = 0; i < 8; i++) begin
                fault('0);
                seen[last_idx] = 1'b1;
                ack();
                repeat (i % 3) idle();
            end
            check($countones(seen) >= 2, "R11 varied choice", $countones(seen), 2);
        end

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            logic rv  = ($urandom % 2) == 0;
            logic rw  = ($urandom % 3) == 0;
            logic tk  = ($urandom % 20) == 0;
            logic fr  = ($urandom % 6) == 0;
            logic ak  = hold && (($urandom % 3) == 0);
            logic [N-1:0] bm = N'($urandom & $urandom & $urandom);
            if (($urandom % 40) == 0) bm = '1;
            cyc(rv, IW'($urandom % N), rw, tk, fr, bm, ak);
        end
        if (hold) ack();
        finish_run();
    end

endmodule